// File: doc/BRIEF.md
# Page-Table Walk Address Generator

This block serves a table-walk refill path. For each command it forms the physical address of one page-table read, issues that read over a valid/ready request channel, and keeps the value that comes back. A command is either a directory step, which yields the pointer to the next-level table, or a leaf step, which yields one of the two entries of an even/odd page pair. The index for each step is cut from the faulting virtual address using a bit position and a bit count. Each directory level has its own pair, and the leaf table has one more. The index is then scaled by a stride picked by a two-bit entry-size code.

When the base value of a command carries the huge-page marker, no table is read. A directory step hands the base straight back. A leaf step builds the entry from the base itself: it clears the marker, moves the huge-global flag into the global position and, for the odd half, offsets the address by one huge page. Every stored result is clipped to the physical address width. A directory step whose level is outside the configured range is refused without a read, and an error flag is raised.

Top module: `ptw_walk_agen`

## Requirements
- R1: After reset `cmd_ready_o` is 1, and `mem_req_valid_o`, `done_o`, `bad_level_o`, `dir_ptr_o`, `leaf_even_o`, `leaf_odd_o` and `leaf_ps_o` are all 0.
- R2: A directory step at level L (1..4) reads address (base & PA mask) | (((va >> P) & (2^W - 1)) << S). P is bits [(L-1)*6+5:(L-1)*6] of `dir_bitpos_i` and W is bits [(L-1)*5+4:(L-1)*5] of `dir_bits_i`. The 64-bit reply, masked to PA_W bits, appears on `dir_ptr_o`.
- R3: The stride S is 3*(code+1) for `pte_code_i` = 0..3, so entries sit 8, 64, 512 or 4096 bytes apart.
- R4: A directory step whose base has bit 6 set issues no read and returns the base masked to PA_W bits, with `bad_level_o` 0. This check runs before the level check.
- R5: A directory step with a level outside 1..4 and base bit 6 clear issues no read, sets `bad_level_o` to 1 and `dir_ptr_o` to 0. The next directory step that does not fail this way clears `bad_level_o`.
- R6: A leaf step with base bit 6 clear reads at (base & PA mask) | (I << S). I is ((va >> `pt_bitpos_i`) & (2^`pt_bits_i` - 1)) with bit 0 replaced by `cmd_odd_i`. The masked reply goes to `leaf_odd_o` when `cmd_odd_i`=1 and to `leaf_even_o` otherwise, and `leaf_ps_o` becomes `pt_bitpos_i`.
- R7: A leaf step with base bit 6 set issues no read. The entry is the masked base with bit 6 replaced by base bit 12. The page size Q = `pt_bitpos_i` + `pt_bits_i` - 1 goes to `leaf_ps_o`. For the odd half, 2^Q is added and the sum is masked to PA_W bits again.
- R8: `mem_req_valid_o` stays high, and `mem_req_addr_o` stays unchanged, until `mem_req_ready_i` is seen.
- R9: `done_o` is a one-cycle pulse per accepted command. `cmd_ready_o` is 0 from acceptance until that pulse, and a command presented meanwhile is ignored.
- R10: A directory step leaves `leaf_even_o`, `leaf_odd_o` and `leaf_ps_o` unchanged. A leaf step leaves `dir_ptr_o` and `bad_level_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command taken |
| cmd_leaf_i | input | 1 | 1 = leaf step, 0 = directory step |
| cmd_level_i | input | 3 | Directory level, valid 1..4 |
| cmd_odd_i | input | 1 | Leaf half select, 1 = odd |
| cmd_base_i | input | 64 | Table base or huge-page value |
| bad_va_i | input | 64 | Faulting virtual address |
| dir_bitpos_i | input | 24 | Index start bit, 6 bits per level, level 1 lowest |
| dir_bits_i | input | 20 | Index bit count, 5 bits per level, level 1 lowest |
| pt_bitpos_i | input | 6 | Leaf index start bit |
| pt_bits_i | input | 5 | Leaf index bit count |
| pte_code_i | input | 2 | Entry size code (stride) |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request taken |
| mem_req_addr_o | output | 48 | Read address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Read data |
| done_o | output | 1 | Result written, one cycle |
| bad_level_o | output | 1 | Last directory step had an invalid level |
| dir_ptr_o | output | 64 | Directory pointer result |
| leaf_even_o | output | 64 | Even leaf entry |
| leaf_odd_o | output | 64 | Odd leaf entry |
| leaf_ps_o | output | 6 | Page size of last leaf step |

## Verification
The hardest case to reach is a command that arrives while the block is busy. It only stays busy long enough if the memory holds back its ready. The bench therefore stretches the request phase with a programmable stall, keeps `cmd_valid_i` asserted with a different command during the stall, and checks that exactly one result arrives. The huge marker is also combined with an invalid level, to show that the huge check wins. Odd virtual indices are used to show that the pair index ignores its low bit.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int XLEN  = 64;
  localparam int LVL_W = 3;

  typedef enum logic {OP_DIR = 1'b0, OP_LEAF = 1'b1} ptw_op_e;

  typedef struct packed {
    ptw_op_e          op;
    logic [LVL_W-1:0] level;
    logic             odd;
    logic [XLEN-1:0]  base;
    logic [XLEN-1:0]  va;
  } ptw_cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_REQ, ST_WAIT} ptw_state_e;
endpackage

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc
  import ptw_pkg::*;
#(
  parameter int PA_W     = 48,
  parameter int N_LEVELS = 4,
  parameter int BPOS_W   = 6,
  parameter int BWID_W   = 5,
  parameter int HUGE_BIT = 6,
  parameter int HGLB_BIT = 12,
  parameter int GLB_BIT  = 6
) (
  input  ptw_cmd_t                     cmd_i,
  input  logic [N_LEVELS*BPOS_W-1:0]   dir_bitpos_i,
  input  logic [N_LEVELS*BWID_W-1:0]   dir_bits_i,
  input  logic [BPOS_W-1:0]            pt_bitpos_i,
  input  logic [BWID_W-1:0]            pt_bits_i,
  input  logic [1:0]                   pte_code_i,
  output logic [PA_W-1:0]              addr_o,
  output logic                         imm_o,
  output logic                         bad_lvl_o,
  output logic [XLEN-1:0]              imm_val_o,
  output logic [BPOS_W-1:0]            ps_o
);
  localparam logic [XLEN-1:0] PA_MASK =
    (PA_W >= XLEN) ? '1 : ((XLEN'(1) << PA_W) - XLEN'(1));

  function automatic logic [XLEN-1:0] low_mask(input logic [BWID_W-1:0] n);
    return (XLEN'(1) << n) - XLEN'(1);
  endfunction

  logic [BPOS_W-1:0] lvl_pos  [N_LEVELS];
  logic [BWID_W-1:0] lvl_bits [N_LEVELS];

  for (genvar g = 0; g < N_LEVELS; g++) begin : g_lvl
    assign lvl_pos[g]  = dir_bitpos_i[g*BPOS_W +: BPOS_W];
    assign lvl_bits[g] = dir_bits_i[g*BWID_W +: BWID_W];
  end

  logic [BPOS_W-1:0] sel_pos;
  logic [BWID_W-1:0] sel_bits;
  logic              lvl_ok;

  always_comb begin
    sel_pos  = '0;
    sel_bits = '0;
    lvl_ok   = 1'b0;
    for (int l = 0; l < N_LEVELS; l++) begin
      if (cmd_i.level == LVL_W'(l + 1)) begin
        sel_pos  = lvl_pos[l];
        sel_bits = lvl_bits[l];
        lvl_ok   = 1'b1;
      end
    end
  end

  logic [3:0]        shamt;
  logic              huge;
  logic [XLEN-1:0]   base_m, dir_idx, ent_idx, off, full;
  logic [XLEN-1:0]   hv_flip, hv_glb, hv_sum;
  logic [BPOS_W-1:0] huge_ps;
  logic              is_dir;

  always_comb begin
    is_dir  = (cmd_i.op == OP_DIR);
    shamt   = {2'b00, pte_code_i} * 4'd3 + 4'd3;
    huge    = cmd_i.base[HUGE_BIT];
    base_m  = cmd_i.base & PA_MASK;
    dir_idx = (cmd_i.va >> sel_pos) & low_mask(sel_bits);
    // pair index: low bit forced to the half being fetched
    ent_idx = (((cmd_i.va >> pt_bitpos_i) & low_mask(pt_bits_i)) & ~XLEN'(1))
              | XLEN'(cmd_i.odd);
    off     = (is_dir ? dir_idx : ent_idx) << shamt;
    full    = base_m | off;
    addr_o  = full[PA_W-1:0];

    huge_ps = pt_bitpos_i + BPOS_W'(pt_bits_i) - BPOS_W'(1);
    hv_flip = base_m ^ (XLEN'(1) << HUGE_BIT);
    hv_glb  = (hv_flip & ~(XLEN'(1) << GLB_BIT)) | (XLEN'(hv_flip[HGLB_BIT]) << GLB_BIT);
    hv_sum  = hv_glb + (cmd_i.odd ? (XLEN'(1) << huge_ps) : '0);

    imm_o     = huge | (is_dir & ~lvl_ok);
    bad_lvl_o = is_dir & ~huge & ~lvl_ok;
    if (is_dir) imm_val_o = huge ? base_m : '0;
    else        imm_val_o = hv_sum & PA_MASK;
    ps_o      = huge ? huge_ps : pt_bitpos_i;
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic imm_i,
  input  logic mem_ready_i,
  input  logic rsp_valid_i,
  output logic ready_o,
  output logic req_valid_o,
  output logic addr_en_o,
  output logic wr_imm_o,
  output logic wr_rsp_o
);
  ptw_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i)     st_d = ST_EVAL;
      ST_EVAL:                  st_d = imm_i ? ST_IDLE : ST_REQ;
      ST_REQ:  if (mem_ready_i) st_d = ST_WAIT;
      ST_WAIT: if (rsp_valid_i) st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign ready_o     = (st_q == ST_IDLE);
  assign req_valid_o = (st_q == ST_REQ);
  assign addr_en_o   = (st_q == ST_EVAL) && !imm_i;
  assign wr_imm_o    = (st_q == ST_EVAL) && imm_i;
  assign wr_rsp_o    = (st_q == ST_WAIT) && rsp_valid_i;

  // huge or bad-level commands finish without touching memory (R4, R5)
  p_imm_no_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EVAL && imm_i) |=> (ready_o && !req_valid_o));

  p_req_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !mem_ready_i) |=> req_valid_o);
endmodule

// File: rtl/ptw_walk_agen.sv
module ptw_walk_agen
  import ptw_pkg::*;
#(
  parameter int PA_W     = 48,
  parameter int N_LEVELS = 4,
  parameter int BPOS_W   = 6,
  parameter int BWID_W   = 5,
  parameter int HUGE_BIT = 6,
  parameter int HGLB_BIT = 12,
  parameter int GLB_BIT  = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_valid_i,
  output logic                       cmd_ready_o,
  input  logic                       cmd_leaf_i,
  input  logic [LVL_W-1:0]           cmd_level_i,
  input  logic                       cmd_odd_i,
  input  logic [XLEN-1:0]            cmd_base_i,
  input  logic [XLEN-1:0]            bad_va_i,
  input  logic [N_LEVELS*BPOS_W-1:0] dir_bitpos_i,
  input  logic [N_LEVELS*BWID_W-1:0] dir_bits_i,
  input  logic [BPOS_W-1:0]          pt_bitpos_i,
  input  logic [BWID_W-1:0]          pt_bits_i,
  input  logic [1:0]                 pte_code_i,
  output logic                       mem_req_valid_o,
  input  logic                       mem_req_ready_i,
  output logic [PA_W-1:0]            mem_req_addr_o,
  input  logic                       mem_rsp_valid_i,
  input  logic [XLEN-1:0]            mem_rsp_data_i,
  output logic                       done_o,
  output logic                       bad_level_o,
  output logic [XLEN-1:0]            dir_ptr_o,
  output logic [XLEN-1:0]            leaf_even_o,
  output logic [XLEN-1:0]            leaf_odd_o,
  output logic [BPOS_W-1:0]          leaf_ps_o
);
  localparam logic [XLEN-1:0] PA_MASK =
    (PA_W >= XLEN) ? '1 : ((XLEN'(1) << PA_W) - XLEN'(1));

  ptw_cmd_t          cmd_q;
  logic              start, imm, bad_lvl, addr_en, wr_imm, wr_rsp, wr;
  logic [PA_W-1:0]   calc_addr, addr_q;
  logic [XLEN-1:0]   imm_val, new_val;
  logic [BPOS_W-1:0] calc_ps;

  assign start = cmd_valid_i && cmd_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (start) begin
      cmd_q.op    <= cmd_leaf_i ? OP_LEAF : OP_DIR;
      cmd_q.level <= cmd_level_i;
      cmd_q.odd   <= cmd_odd_i;
      cmd_q.base  <= cmd_base_i;
      cmd_q.va    <= bad_va_i;
    end
  end

  ptw_addr_calc #(
    .PA_W(PA_W), .N_LEVELS(N_LEVELS), .BPOS_W(BPOS_W), .BWID_W(BWID_W),
    .HUGE_BIT(HUGE_BIT), .HGLB_BIT(HGLB_BIT), .GLB_BIT(GLB_BIT)
  ) u_calc (
    .cmd_i(cmd_q), .dir_bitpos_i(dir_bitpos_i), .dir_bits_i(dir_bits_i),
    .pt_bitpos_i(pt_bitpos_i), .pt_bits_i(pt_bits_i), .pte_code_i(pte_code_i),
    .addr_o(calc_addr), .imm_o(imm), .bad_lvl_o(bad_lvl),
    .imm_val_o(imm_val), .ps_o(calc_ps)
  );

  ptw_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .imm_i(imm),
    .mem_ready_i(mem_req_ready_i), .rsp_valid_i(mem_rsp_valid_i),
    .ready_o(cmd_ready_o), .req_valid_o(mem_req_valid_o),
    .addr_en_o(addr_en), .wr_imm_o(wr_imm), .wr_rsp_o(wr_rsp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (addr_en) addr_q <= calc_addr;
  end
  assign mem_req_addr_o = addr_q;

  assign wr      = wr_imm | wr_rsp;
  assign new_val = wr_imm ? imm_val : (mem_rsp_data_i & PA_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      bad_level_o <= 1'b0;
      dir_ptr_o   <= '0;
      leaf_even_o <= '0;
      leaf_odd_o  <= '0;
      leaf_ps_o   <= '0;
    end else begin
      done_o <= wr;
      if (wr) begin
        if (cmd_q.op == OP_DIR) begin
          dir_ptr_o   <= new_val;
          bad_level_o <= wr_imm & bad_lvl;
        end else begin
          if (cmd_q.odd) leaf_odd_o  <= new_val;
          else           leaf_even_o <= new_val;
          leaf_ps_o <= calc_ps;
        end
      end
    end
  end

  p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> $stable(mem_req_addr_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !cmd_ready_o);

  p_bad_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && bad_level_o) |-> (dir_ptr_o == '0));

  p_leaf_keeps_dir_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cmd_q.op == OP_LEAF) |-> ($stable(dir_ptr_o) && $stable(bad_level_o)));
endmodule

// File: tb/sim_ptw_walk_agen.sv
`timescale 1ns/1ps
module sim_ptw_walk_agen;
  localparam logic [63:0] PAM = (64'd1 << 48) - 64'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cmd_valid_i = 0, cmd_leaf_i = 0, cmd_odd_i = 0;
  logic [2:0]  cmd_level_i = 0;
  logic [63:0] cmd_base_i = 0, bad_va_i = 0;
  logic [23:0] dir_bitpos_i = {6'd48, 6'd39, 6'd30, 6'd21};
  logic [19:0] dir_bits_i   = {5'd0, 5'd9, 5'd9, 5'd9};
  logic [5:0]  pt_bitpos_i  = 6'd12;
  logic [4:0]  pt_bits_i    = 5'd9;
  logic [1:0]  pte_code_i   = 2'd0;
  logic        mem_req_ready_i, mem_rsp_valid_i;
  logic [63:0] mem_rsp_data_i;
  logic        cmd_ready_o, mem_req_valid_o, done_o, bad_level_o;
  logic [47:0] mem_req_addr_o;
  logic [63:0] dir_ptr_o, leaf_even_o, leaf_odd_o;
  logic [5:0]  leaf_ps_o;

  ptw_walk_agen u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o), .cmd_leaf_i(cmd_leaf_i),
    .cmd_level_i(cmd_level_i), .cmd_odd_i(cmd_odd_i), .cmd_base_i(cmd_base_i),
    .bad_va_i(bad_va_i), .dir_bitpos_i(dir_bitpos_i), .dir_bits_i(dir_bits_i),
    .pt_bitpos_i(pt_bitpos_i), .pt_bits_i(pt_bits_i), .pte_code_i(pte_code_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .done_o(done_o), .bad_level_o(bad_level_o),
    .dir_ptr_o(dir_ptr_o), .leaf_even_o(leaf_even_o), .leaf_odd_o(leaf_odd_o),
    .leaf_ps_o(leaf_ps_o)
  );

  int n_chk = 0, n_err = 0;
  int rd_cnt = 0, rd_mark = 0, mem_stall = 0;
  logic [47:0] last_addr = '0;

  typedef struct {
    bit          rd;
    logic [47:0] addr;
    logic [63:0] dptr, lo0, lo1;
    logic [5:0]  ps;
    bit          bad;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  logic [63:0] m_dptr = 0, m_lo0 = 0, m_lo1 = 0;
  logic [5:0]  m_ps = 0;
  bit          m_bad = 0;

  function automatic logic [63:0] mem_fn(input logic [63:0] a);
    return {a[15:0] ^ 16'hBEEF, a[47:0] ^ 48'h5A5A_0F0F_3C3C};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_req_ready_i = 0; mem_rsp_valid_i = 0; mem_rsp_data_i = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid_i = 0;
      if (rst_n && mem_req_valid_o) begin
        repeat (mem_stall) @(negedge clk);
        mem_req_ready_i = 1;
        last_addr = mem_req_addr_o;
        rd_cnt++;
        @(negedge clk);
        mem_req_ready_i = 0;
        mem_rsp_data_i  = mem_fn({16'h0, last_addr});
        mem_rsp_valid_i = 1;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    exp_t it;
    forever begin
      @(negedge clk);
      if (rst_n && done_o) begin
        if (sbq.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL R9 unexpected done act=1 exp=0");
        end else begin
          it = sbq.pop_front();
          chk(it.tag, "dir_ptr", dir_ptr_o, it.dptr);
          chk(it.tag, "leaf_even", leaf_even_o, it.lo0);
          chk(it.tag, "leaf_odd", leaf_odd_o, it.lo1);
          chk(it.tag, "leaf_ps", 64'(leaf_ps_o), 64'(it.ps));
          chk(it.tag, "bad_level", 64'(bad_level_o), 64'(it.bad));
          chk(it.tag, "reads", 64'(rd_cnt - rd_mark), 64'(it.rd));
          if (it.rd) chk(it.tag, "addr", 64'(last_addr), 64'(it.addr));
          rd_mark = rd_cnt;
        end
      end
    end
  end

  task automatic issue(input bit leaf, input logic [2:0] lvl, input bit odd,
                       input logic [63:0] base, input logic [63:0] va,
                       input string tag, input bit linger = 0);
    exp_t e;
    int sh, li;
    logic [63:0] idx, a, v;
    logic [5:0] pos, hps;
    logic [4:0] w;
    sh = 3 * (int'(pte_code_i) + 1);
    e.rd = 0; e.addr = '0;
    if (!leaf) begin
      if (base[6]) begin
        m_dptr = base & PAM; m_bad = 0;
      end else if (lvl < 3'd1 || lvl > 3'd4) begin
        m_dptr = 0; m_bad = 1;
      end else begin
        li  = int'(lvl) - 1;
        pos = dir_bitpos_i[li*6 +: 6];
        w   = dir_bits_i[li*5 +: 5];
        idx = (va >> pos) & ((64'd1 << w) - 64'd1);
        a   = ((base & PAM) | (idx << sh)) & PAM;
        e.rd = 1; e.addr = a[47:0];
        m_dptr = mem_fn(a) & PAM; m_bad = 0;
      end
    end else begin
      if (base[6]) begin
        v = base & PAM;
        v[6] = v[12];
        hps = pt_bitpos_i + 6'(pt_bits_i) - 6'd1;
        if (odd) v = v + (64'd1 << hps);
        v = v & PAM;
        m_ps = hps;
      end else begin
        idx = (va >> pt_bitpos_i) & ((64'd1 << pt_bits_i) - 64'd1);
        idx[0] = odd;
        a = ((base & PAM) | (idx << sh)) & PAM;
        e.rd = 1; e.addr = a[47:0];
        v = mem_fn(a) & PAM;
        m_ps = pt_bitpos_i;
      end
      if (odd) m_lo1 = v; else m_lo0 = v;
    end
    e.dptr = m_dptr; e.lo0 = m_lo0; e.lo1 = m_lo1; e.ps = m_ps; e.bad = m_bad;
    e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    while (!cmd_ready_o) @(negedge clk);
    cmd_leaf_i = leaf; cmd_level_i = lvl; cmd_odd_i = odd;
    cmd_base_i = base; bad_va_i = va; cmd_valid_i = 1;
    @(negedge clk);
    if (linger) begin
      for (int k = 0; k < 2; k++) begin
        cmd_level_i = lvl ^ 3'd3; cmd_base_i = ~base; cmd_leaf_i = ~leaf;
        chk("R9", "ready_busy", 64'(cmd_ready_o), 64'd0);
        @(negedge clk);
      end
    end
    cmd_valid_i = 0;
    while (sbq.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cmd_ready", 64'(cmd_ready_o), 64'd1);
    chk("R1", "mem_req_valid", 64'(mem_req_valid_o), 64'd0);
    chk("R1", "done", 64'(done_o), 64'd0);
    chk("R1", "bad_level", 64'(bad_level_o), 64'd0);
    chk("R1", "dir_ptr", dir_ptr_o, 64'd0);
    chk("R1", "leaf_even", leaf_even_o, 64'd0);
    chk("R1", "leaf_odd", leaf_odd_o, 64'd0);
    chk("R1", "leaf_ps", 64'(leaf_ps_o), 64'd0);

    mem_stall = 0; pte_code_i = 2'd0;
    issue(0, 3'd1, 0, 64'h0000_0012_3450_0000, 64'h0000_7A5B_3C2D_1E0F, "R2 level1");
    mem_stall = 1; pte_code_i = 2'd1;
    issue(0, 3'd2, 0, 64'h0000_0ABC_0000_0000, 64'h0000_6F3E_9D2C_4B1A, "R2 R3 R8 level2");
    mem_stall = 2; pte_code_i = 2'd3;
    issue(0, 3'd3, 0, 64'h0000_4000_0000_0000, 64'h0000_5555_AAAA_1234, "R3 R8 level3");
    pte_code_i = 2'd2; mem_stall = 0;
    issue(0, 3'd4, 0, 64'h0000_0000_7777_0000, 64'h0000_FFFF_FFFF_FFFF, "R2 level4 zero width");
    issue(0, 3'd2, 0, 64'hFFFF_0012_3456_7040, 64'h0000_1111_2222_3333, "R4 huge dir");
    issue(0, 3'd0, 0, 64'h0000_0000_1000_0000, 64'h0000_1111_2222_3333, "R5 level0");
    issue(0, 3'd5, 0, 64'h0000_0000_1000_0000, 64'h0000_1111_2222_3333, "R5 level5");
    issue(0, 3'd1, 0, 64'h0000_0000_2000_0000, 64'h0000_0123_4567_89AB, "R5 clear");
    issue(0, 3'd7, 0, 64'h0000_0000_0040_0040, 64'h0, "R4 R5 huge wins");
    pte_code_i = 2'd0;
    issue(1, 3'd0, 0, 64'h0000_0000_0080_0000, 64'h0000_0000_0012_3000, "R6 leaf even");
    issue(1, 3'd0, 1, 64'h0000_0000_0080_0000, 64'h0000_0000_0012_3000, "R6 leaf odd");
    pte_code_i = 2'd3; mem_stall = 1;
    issue(1, 3'd0, 0, 64'h0000_0100_0000_0000, 64'h0000_0000_0055_5000, "R6 R3 leaf stride");
    mem_stall = 0;
    issue(0, 3'd1, 0, 64'h0000_0000_3000_0000, 64'h0000_0000_0ABC_0000, "R10 dir keeps leaf");
    pt_bits_i = 5'd11;
    issue(1, 3'd0, 0, 64'hF000_0000_4020_1040, 64'h0, "R7 huge even glb1");
    issue(1, 3'd0, 1, 64'h0000_FFFF_FFE0_0040, 64'h0, "R7 huge odd glb0 wrap");
    pt_bits_i = 5'd9; pte_code_i = 2'd1; mem_stall = 3;
    issue(0, 3'd2, 0, 64'h0000_0000_5000_0000, 64'h0000_3333_4444_5555, "R9 R8 busy ignore", 1);
    mem_stall = 0;
    repeat (5) @(negedge clk);
    chk("R9", "no extra done", 64'(sbq.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule